// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This unit is the decimal-adjust stage of an 8-bit processor datapath. After the ALU has added or subtracted two packed-BCD bytes in binary, the unit takes the stored result byte and corrects it so that it once more holds two decimal digits. Four pieces of state pick the correction and the new carry: the carry flag, the half-carry flag, the ranges of the two nibbles, and the decimal flag, which says whether the last operation was an add or a subtract. The corrected byte goes back into the same register. Carry, zero and sign are updated. Half-carry and the decimal flag are left as they were.

The unit holds a small register file and the five status flags. It accepts ALU write-back through a byte write port and a flag load port. A start pulse names the destination with an 8-bit operand. An operand whose upper nibble is 1110b selects a working register: its address is the 4-bit register pointer followed by the operand's low nibble. Any other operand is a direct register address. The adjust completes on the clock edge that samples start, and done is high for the following cycle.

Top module: `bcd_adjust_unit`

## Requirements
- R1: With the decimal flag (D) clear, C=0 and H=0, the correction is chosen from the two nibbles (upper hi, lower lo). hi 0-9 with lo 0-9 adds 00 and gives carry 0. hi 0-8 with lo A-F adds 06 and gives carry 0. hi A-F with lo 0-9 adds 60 and gives carry 1. hi 9-F with lo A-F adds 66 and gives carry 1. All corrections are added modulo 256.
- R2: With D clear, C=0 and H=1, a byte with lo 0-3 gets 06 and carry 0 when hi is 0-9. It gets 66 and carry 1 when hi is A-F.
- R3: With D clear and C=1, every correction gives carry 1. H=0 with hi 0-2 adds 60 when lo is 0-9 and 66 when lo is A-F. H=1 with hi 0-3 and lo 0-3 adds 66.
- R4: With D set, the corrections are as follows. C=0 and H=0 with both nibbles 0-9 adds 00 and gives carry 0. C=0 and H=1 with hi 0-8 and lo 6-F adds FA and gives carry 0. C=1 and H=0 with hi 7-F and lo 0-9 adds A0 and gives carry 1. C=1 and H=1 with both nibbles 6-F adds 9A and gives carry 1.
- R5: A combination of flags and nibbles that matches none of the rules in R1-R4 leaves the byte unchanged and leaves the carry flag at its old value.
- R6: After an adjust, Z is 1 exactly when the corrected byte is 00.
- R7: After an adjust, S equals bit 7 of the corrected byte.
- R8: An adjust never changes H or D.
- R9: An operand with upper nibble 1110b addresses register {reg_ptr, operand[3:0]}. Any other operand addresses register operand[7:0] directly. An adjust leaves every other register untouched.
- R10: When start is sampled high on a rising edge, the corrected byte and the flags are written on that edge. done and result are valid during the next cycle only, and done is low in a cycle that does not follow a start.
- R11: Reset clears every register, all flags, done and result. The flag vector is ordered {C,Z,S,H,D}, with C at bit 4 and D at bit 0.
- R12: wr_en writes wr_data to register wr_addr. flag_we loads flag_in into the flags. Both take effect on the next rising edge, and start takes priority over both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Perform one decimal adjust this cycle |
| dst_opnd | input | 8 | Destination operand (working or direct register) |
| reg_ptr | input | 4 | Register pointer for working-register operands |
| wr_en | input | 1 | ALU write-back enable |
| wr_addr | input | 8 | ALU write-back address |
| wr_data | input | 8 | ALU write-back byte |
| flag_we | input | 1 | Load the flags from flag_in |
| flag_in | input | 5 | New flags {C,Z,S,H,D} |
| rd_addr | input | 8 | Observation read address |
| rd_data | output | 8 | Register contents at rd_addr (combinational) |
| flags | output | 5 | Current flags {C,Z,S,H,D} |
| result | output | 8 | Corrected byte of the last adjust |
| done | output | 1 | One-cycle strobe after an adjust |

## Verification
A wrong table entry or a wrong range bound shows up in the cycle right after start, as a wrong result byte or a wrong carry bit. The same byte can then be read back through rd_data. A fault in the operand decoder makes the adjust write to the wrong register. That shows as an unchanged target register and a changed neighbour, which can be read at once. A corrupted H or D, or a carry that moves on an undefined input, appears in the flags output in that same following cycle. The fault can then persist until the flags are next loaded.

// File: rtl/da_pkg.sv
// Package da_pkg
// Shared widths and types for the decimal adjust unit.
// Assumes an 8-bit data byte made of two 4-bit digits.
package da_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    // Status flags; packed order gives C at bit 4 down to D at bit 0.
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic h;
        logic d;
    } flags_t;

    // Outcome of the correction lookup.
    typedef struct packed {
        logic [BYTE_W-1:0] corr;
        logic              cout;
        logic              valid;
    } corr_t;
endpackage

// File: rtl/da_corr_table.sv
// Module da_corr_table
// Picks the correction byte and the carry-out from the carry, half-carry
// and decimal flags together with the ranges of the two nibbles.
// Assumes nothing about how the byte was produced; inputs that match no
// rule give valid=0, correction 0 and cout=0 (the caller keeps its carry).
module da_corr_table
    import da_pkg::*;
(
    input  logic              c_in,
    input  logic              h_in,
    input  logic              d_in,
    input  logic [BYTE_W-1:0] byte_in,
    output corr_t             sel
);
    logic [NIB_W-1:0] hi;
    logic [NIB_W-1:0] lo;

    assign hi = byte_in[BYTE_W-1:NIB_W];
    assign lo = byte_in[NIB_W-1:0];

    function automatic logic in_rng(input logic [NIB_W-1:0] v,
                                    input logic [NIB_W-1:0] lo_b,
                                    input logic [NIB_W-1:0] hi_b);
        return (v >= lo_b) && (v <= hi_b);
    endfunction

    function automatic corr_t mk(input logic [BYTE_W-1:0] k, input logic co);
        corr_t r;
        r.corr  = k;
        r.cout  = co;
        r.valid = 1'b1;
        return r;
    endfunction

    // Range lookup, one branch per flag combination.
    always_comb begin
        sel = '0;
        if (!d_in) begin
            unique case ({c_in, h_in})
                2'b00: begin
                    if      (in_rng(hi, 4'h0, 4'h9) && in_rng(lo, 4'h0, 4'h9)) sel = mk(8'h00, 1'b0);
                    else if (in_rng(hi, 4'h0, 4'h8) && in_rng(lo, 4'hA, 4'hF)) sel = mk(8'h06, 1'b0);
                    else if (in_rng(hi, 4'hA, 4'hF) && in_rng(lo, 4'h0, 4'h9)) sel = mk(8'h60, 1'b1);
                    else if (in_rng(hi, 4'h9, 4'hF) && in_rng(lo, 4'hA, 4'hF)) sel = mk(8'h66, 1'b1);
                end
                2'b01: begin
                    if      (in_rng(hi, 4'h0, 4'h9) && in_rng(lo, 4'h0, 4'h3)) sel = mk(8'h06, 1'b0);
                    else if (in_rng(hi, 4'hA, 4'hF) && in_rng(lo, 4'h0, 4'h3)) sel = mk(8'h66, 1'b1);
                end
                2'b10: begin
                    if      (in_rng(hi, 4'h0, 4'h2) && in_rng(lo, 4'h0, 4'h9)) sel = mk(8'h60, 1'b1);
                    else if (in_rng(hi, 4'h0, 4'h2) && in_rng(lo, 4'hA, 4'hF)) sel = mk(8'h66, 1'b1);
                end
                default: begin
                    if (in_rng(hi, 4'h0, 4'h3) && in_rng(lo, 4'h0, 4'h3)) sel = mk(8'h66, 1'b1);
                end
            endcase
        end else begin
            unique case ({c_in, h_in})
                2'b00: if (in_rng(hi, 4'h0, 4'h9) && in_rng(lo, 4'h0, 4'h9)) sel = mk(8'h00, 1'b0);
                2'b01: if (in_rng(hi, 4'h0, 4'h8) && in_rng(lo, 4'h6, 4'hF)) sel = mk(8'hFA, 1'b0);
                2'b10: if (in_rng(hi, 4'h7, 4'hF) && in_rng(lo, 4'h0, 4'h9)) sel = mk(8'hA0, 1'b1);
                default: if (in_rng(hi, 4'h6, 4'hF) && in_rng(lo, 4'h6, 4'hF)) sel = mk(8'h9A, 1'b1);
            endcase
        end
    end

    // R5: an unmatched input must carry no correction.
    always_comb begin
        if (!sel.valid) assert_undef_zero_corr_R5: assert (sel.corr == '0 && !sel.cout);
    end
endmodule

// File: rtl/da_opnd_map.sv
// Module da_opnd_map
// Turns an 8-bit destination operand into a register-file address.
// Assumes ADDR_W equals PTR_W plus one nibble; the tag nibble marks a
// working-register operand, which is placed under the register pointer.
module da_opnd_map
    import da_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PTR_W  = 4,
    parameter logic [NIB_W-1:0] WREG_TAG = 4'hE
) (
    input  logic [BYTE_W-1:0] opnd,
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] addr
);
    localparam int LOW_W = ADDR_W - PTR_W;

    // Select working-register or direct addressing.
    always_comb begin
        if (opnd[BYTE_W-1:NIB_W] == WREG_TAG)
            addr = {ptr, opnd[LOW_W-1:0]};
        else
            addr = opnd[ADDR_W-1:0];
    end
endmodule

// File: rtl/da_regfile.sv
// Module da_regfile
// Register file with one synchronous write port and two combinational
// read ports. Every entry clears on synchronous active-low reset.
module da_regfile
    import da_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [BYTE_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [BYTE_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/bcd_adjust_unit.sv
// Module bcd_adjust_unit
// Decimal-adjust unit: on start, reads the addressed byte, adds the
// correction from the lookup, writes the byte back and updates C, Z and S,
// leaving H and D alone. Assumes start and the write/flag ports come from a
// single issuing stage; start has priority over them in the same cycle.
module bcd_adjust_unit
    import da_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        dst_opnd,
    input  logic [PTR_W-1:0]  reg_ptr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              flag_we,
    input  logic [4:0]        flag_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [4:0]        flags,
    output logic [7:0]        result,
    output logic              done
);
    flags_t            flg_q;
    corr_t             tbl;
    logic [ADDR_W-1:0] dst_addr;
    logic [BYTE_W-1:0] dst_byte;
    logic [BYTE_W-1:0] adj_byte;
    logic              rf_we;
    logic [ADDR_W-1:0] rf_waddr;
    logic [BYTE_W-1:0] rf_wdata;
    logic [BYTE_W-1:0] result_q;
    logic              done_q;
    logic              undef_q;

    da_opnd_map #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_map (
        .opnd (dst_opnd),
        .ptr  (reg_ptr),
        .addr (dst_addr)
    );

    da_regfile #(.ADDR_W(ADDR_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (dst_addr),
        .rdata_a (dst_byte),
        .raddr_b (rd_addr),
        .rdata_b (rd_data)
    );

    da_corr_table u_tbl (
        .c_in    (flg_q.c),
        .h_in    (flg_q.h),
        .d_in    (flg_q.d),
        .byte_in (dst_byte),
        .sel     (tbl)
    );

    // Corrected byte, modulo 256.
    assign adj_byte = dst_byte + tbl.corr;

    // Write-port arbitration: adjust before ALU write-back.
    always_comb begin
        rf_we    = start | wr_en;
        rf_waddr = start ? dst_addr : wr_addr;
        rf_wdata = start ? adj_byte : wr_data;
    end

    // Flags, result, done strobe and undefined status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            undef_q  <= 1'b0;
        end else if (start) begin
            flg_q.c  <= tbl.valid ? tbl.cout : flg_q.c;
            flg_q.z  <= (adj_byte == '0);
            flg_q.s  <= adj_byte[BYTE_W-1];
            result_q <= adj_byte;
            done_q   <= 1'b1;
            undef_q  <= !tbl.valid;
        end else begin
            done_q <= 1'b0;
            if (flag_we) flg_q <= flag_in;
        end
    end

    assign flags  = flg_q;
    assign result = result_q;
    assign done   = done_q;

    // R10: done follows a start by one cycle and only then.
    assert_done_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_no_stray_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R8: half-carry and decimal flags survive an adjust.
    assert_hd_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (flg_q.h == $past(flg_q.h)) && (flg_q.d == $past(flg_q.d)));
    // R5: an unmatched input leaves the carry as it was.
    assert_undef_carry_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !tbl.valid) |=> flg_q.c == $past(flg_q.c));
    // R6: zero flag tracks the result.
    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flg_q.z == (result_q == '0));
    // R7: sign flag tracks the result.
    assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flg_q.s == result_q[BYTE_W-1]);
    // R4 (and R1-R3): a matched rule always yields two decimal digits.
    assert_bcd_digits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !undef_q) |-> (result_q[7:4] <= 4'd9) && (result_q[3:0] <= 4'd9));
endmodule

// File: tb/tb_bcd_adjust_unit.sv
module tb_bcd_adjust_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [7:0] dst_opnd;
    logic [3:0] reg_ptr;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       flag_we;
    logic [4:0] flag_in;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic [4:0] flags;
    logic [7:0] result;
    logic       done;

    int checks = 0;
    int errors = 0;

    bcd_adjust_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_opnd(dst_opnd),
        .reg_ptr(reg_ptr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_we(flag_we), .flag_in(flag_in), .rd_addr(rd_addr),
        .rd_data(rd_data), .flags(flags), .result(result), .done(done)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // flags order {C,Z,S,H,D}
    task automatic load_flags(input logic c, input logic h, input logic d);
        @(negedge clk);
        flag_we = 1'b1; flag_in = {c, 1'b0, 1'b0, h, d};
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    // Pulse start; afterwards the bench is at the negedge of the done cycle.
    task automatic pulse_adjust(input logic [7:0] opnd);
        @(negedge clk);
        start = 1'b1; dst_opnd = opnd;
        @(negedge clk);
        start = 1'b0;
    endtask

    // One adjust on a direct register, checked against expected byte and carry.
    task automatic run_case(input string tag, input logic [7:0] a,
                            input logic [7:0] v, input logic c, input logic h,
                            input logic d, input logic [7:0] exp_b,
                            input logic exp_c);
        logic [4:0] exp_f;
        write_byte(a, v);
        load_flags(c, h, d);
        pulse_adjust(a);
        exp_f = {exp_c, (exp_b == 8'h00), exp_b[7], h, d};
        chk(tag, "done", done, 1'b1);
        chk(tag, "result", result, exp_b);
        chk(tag, "flags", flags, exp_f);
        rd_addr = a;
        #1;
        chk(tag, "stored byte", rd_data, exp_b);
    endtask

    task automatic t_reset;
        chk("R11", "done", done, 1'b0);
        chk("R11", "flags", flags, 5'h00);
        chk("R11", "result", result, 8'h00);
        rd_addr = 8'h10; #1;
        chk("R11", "reg 10", rd_data, 8'h00);
        rd_addr = 8'hEC; #1;
        chk("R11", "reg EC", rd_data, 8'h00);
    endtask

    task automatic t_add_c0h0;
        run_case("R1", 8'h10, 8'h45, 0, 0, 0, 8'h45, 0);
        run_case("R1", 8'h10, 8'h4C, 0, 0, 0, 8'h52, 0);
        run_case("R1", 8'h10, 8'hA5, 0, 0, 0, 8'h05, 1);
        run_case("R1", 8'h10, 8'h9B, 0, 0, 0, 8'h01, 1);
        run_case("R1", 8'h10, 8'h8F, 0, 0, 0, 8'h95, 0);
    endtask

    task automatic t_add_c0h1;
        run_case("R2", 8'h11, 8'h93, 0, 1, 0, 8'h99, 0);
        run_case("R2", 8'h11, 8'hB2, 0, 1, 0, 8'h18, 1);
    endtask

    task automatic t_add_c1;
        run_case("R3", 8'h12, 8'h25, 1, 0, 0, 8'h85, 1);
        run_case("R3", 8'h12, 8'h1C, 1, 0, 0, 8'h82, 1);
        run_case("R3", 8'h12, 8'h33, 1, 1, 0, 8'h99, 1);
    endtask

    task automatic t_sub;
        run_case("R4", 8'h13, 8'h38, 0, 0, 1, 8'h38, 0);
        run_case("R4", 8'h13, 8'h5C, 0, 1, 1, 8'h56, 0);
        run_case("R4", 8'h13, 8'h85, 1, 0, 1, 8'h25, 1);
        run_case("R4", 8'h13, 8'h7B, 1, 1, 1, 8'h15, 1);
    endtask

    task automatic t_undef;
        run_case("R5", 8'h14, 8'h47, 1, 1, 0, 8'h47, 1);
        run_case("R5", 8'h14, 8'h18, 0, 1, 0, 8'h18, 0);
        run_case("R5", 8'h14, 8'h35, 1, 0, 1, 8'h35, 1);
    endtask

    task automatic t_zero_sign;
        run_case("R6", 8'h15, 8'h9A, 0, 0, 0, 8'h00, 1);
        run_case("R6", 8'h15, 8'h00, 0, 0, 0, 8'h00, 0);
        run_case("R7", 8'h15, 8'h9F, 0, 0, 1, 8'h9F, 0);
    endtask

    task automatic t_hd_kept;
        run_case("R8", 8'h16, 8'h66, 1, 1, 1, 8'h00, 1);
        chk("R8", "H and D", {flags[1], flags[0]}, 2'b11);
    endtask

    task automatic t_map;
        write_byte(8'h3C, 8'h4C);
        write_byte(8'h5C, 8'h4C);
        write_byte(8'hEC, 8'h4C);
        load_flags(0, 0, 0);
        reg_ptr = 4'h3;
        pulse_adjust(8'hEC);
        chk("R9", "result", result, 8'h52);
        rd_addr = 8'h3C; #1; chk("R9", "reg 3C", rd_data, 8'h52);
        rd_addr = 8'h5C; #1; chk("R9", "reg 5C", rd_data, 8'h4C);
        rd_addr = 8'hEC; #1; chk("R9", "reg EC", rd_data, 8'h4C);
        reg_ptr = 4'h5;
        pulse_adjust(8'hEC);
        rd_addr = 8'h5C; #1; chk("R9", "reg 5C ptr5", rd_data, 8'h52);
        rd_addr = 8'h3C; #1; chk("R9", "reg 3C ptr5", rd_data, 8'h52);
        reg_ptr = 4'h0;
        pulse_adjust(8'hDC);
        rd_addr = 8'hDC; #1; chk("R9", "reg DC direct", rd_data, 8'h00);
    endtask

    task automatic t_timing;
        write_byte(8'h20, 8'hA5);
        load_flags(0, 0, 0);
        pulse_adjust(8'h20);
        chk("R10", "done high", done, 1'b1);
        @(negedge clk);
        chk("R10", "done one cycle", done, 1'b0);
        chk("R10", "result held", result, 8'h05);
    endtask

    task automatic t_ports;
        // start and flag load together: adjust wins, flags not loaded.
        write_byte(8'h21, 8'h4C);
        load_flags(0, 0, 0);
        @(negedge clk);
        start = 1'b1; dst_opnd = 8'h21; flag_we = 1'b1; flag_in = 5'b11111;
        @(negedge clk);
        start = 1'b0; flag_we = 1'b0;
        chk("R12", "flags priority", flags, 5'b00000);
        load_flags(1, 0, 1);
        chk("R12", "flag load", flags, 5'b10001);
        write_byte(8'h22, 8'h77);
        rd_addr = 8'h22; #1;
        chk("R12", "write port", rd_data, 8'h77);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; dst_opnd = '0; reg_ptr = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; flag_we = 1'b0;
        flag_in = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add_c0h0();
        t_add_c0h1();
        t_add_c1();
        t_sub();
        t_undef();
        t_zero_sign();
        t_hd_kept();
        t_map();
        t_timing();
        t_ports();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule